// File: doc/BRIEF.md
# Edge/Level Interrupt Aggregation Controller

This block gathers 64 interrupt request inputs and forwards them to 64 upstream interrupt lines. Each input is set to edge-sensitive or level-sensitive capture. Captured requests sit in a pending register, and a 64-bit mask gates them. When a request is allowed through, it is marked in-service and drives the upstream line that its own vector table entry selects. If several requests qualify in the same cycle, the lowest-numbered one is taken.

Software reaches the controller over a simple single-cycle register bus. Each 64-bit control register appears as two 32-bit words, low and high. The per-input vector and route tables are reached one byte per access. A write to the mask runs a new evaluation on exactly the bits whose mask state changed. A write to the clear register retires edge-captured requests. The status register shows the in-service requests that are not masked.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset the mask reads all ones and the following read as zero: edge-select, status, polarity and message-enable. Every route entry reads 1, every vector entry reads 0, and all `irq_out` lines are low.
- R2: Word map: mask 0x020/0x024, edge-select 0x040/0x044 (bit=1 edge, 0 level), clear 0x060/0x064, message-enable 0x080/0x084, status 0x300/0x304, polarity 0x320/0x324. The low word sits at the first address and covers bits 31:0. A write to one word leaves the other word unchanged. The identification words at 0x000/0x004 are constants that ignore writes. The auto-control words 0x0A0..0x0AC and both clear words read zero, and writes to the auto-control words have no effect.
- R3: In edge mode a pending bit is set when the input is high and its last sampled level was low. A falling input does not clear the pending bit, but it runs a deassertion evaluation on that input.
- R4: In level mode the pending bit follows the input. A falling input runs a deassertion evaluation on that input.
- R5: An assertion evaluation takes the lowest-numbered bit that is in its event set, pending and unmasked. It marks that bit in-service and drives high the line given by bits 5:0 of its vector entry. At most one line rises per cycle.
- R6: A deassertion evaluation takes the lowest-numbered bit that is in its event set and in service. It clears that bit's in-service flag and drives its line low.
- R7: A mask-word write runs an assertion evaluation on exactly the newly unmasked bits and a deassertion evaluation on exactly the newly masked bits.
- R8: A clear-word write affects only edge-mode bits. For those bits it clears pending and in-service and runs a deassertion evaluation. Level-mode bits named in the write keep their state and their line.
- R9: A status read returns in-service AND NOT mask. A status write replaces that half of the in-service register and does not change `irq_out`.
- R10: The route table is at 0x100+i and the vector table at 0x200+i, with one byte in wdata[7:0]/rdata[7:0]. An index of 64 or more within either page reads zero and ignores writes.
- R11: A register write takes effect at the clock edge on which `bus_wr` is sampled high. Reads are combinational and need no wait state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 64 | Interrupt request inputs, synchronous to clk |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data (byte accesses use bits 7:0) |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | 64 | Upstream interrupt lines |

## Verification
The assertions take for granted that `irq_in` is already synchronous to `clk` and that reset is held low for at least one edge at start-up. They also assume that `bus_addr` is always a known value, because the status-masking and single-rise properties are sampled on every cycle. The stimulus drives both inputs and bus fields only on the falling edge and issues one bus operation at a time. It keeps input changes and bus writes in separate cycles, so each evaluation's event set comes from a single cause.

// File: rtl/irq_agg_pkg.sv
// Package: address map and page codes shared by the controller and its bench.
// Assumes a 12-bit byte address; word registers are 32-bit aligned.
package irq_agg_pkg;
    localparam logic [11:0] A_ID_LO   = 12'h000;
    localparam logic [11:0] A_ID_HI   = 12'h004;
    localparam logic [11:0] A_MASK_LO = 12'h020;
    localparam logic [11:0] A_MASK_HI = 12'h024;
    localparam logic [11:0] A_EDGE_LO = 12'h040;
    localparam logic [11:0] A_EDGE_HI = 12'h044;
    localparam logic [11:0] A_CLR_LO  = 12'h060;
    localparam logic [11:0] A_CLR_HI  = 12'h064;
    localparam logic [11:0] A_MSG_LO  = 12'h080;
    localparam logic [11:0] A_MSG_HI  = 12'h084;
    localparam logic [11:0] A_AUTO0   = 12'h0A0;
    localparam logic [11:0] A_AUTO1   = 12'h0A4;
    localparam logic [11:0] A_AUTO2   = 12'h0A8;
    localparam logic [11:0] A_AUTO3   = 12'h0AC;
    localparam logic [11:0] A_STAT_LO = 12'h300;
    localparam logic [11:0] A_STAT_HI = 12'h304;
    localparam logic [11:0] A_POL_LO  = 12'h320;
    localparam logic [11:0] A_POL_HI  = 12'h324;
    localparam logic [3:0]  PG_ROUTE  = 4'h1;
    localparam logic [3:0]  PG_VEC    = 4'h2;
endpackage

// File: rtl/irq_capture.sv
// Module: irq_capture
// Samples the request inputs against their last seen level and keeps the
// pending register. Edge bits latch on a rising input and are only cleared
// by the clear mask; level bits follow the input.
// Assumes irq_in is synchronous to clk.
module irq_capture #(
    parameter int NSRC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic [NSRC-1:0] edge_sel,
    input  logic [NSRC-1:0] clr_bits,
    output logic [NSRC-1:0] rise,
    output logic [NSRC-1:0] fall,
    output logic [NSRC-1:0] pend_next
);
    logic [NSRC-1:0] last_q;
    logic [NSRC-1:0] pend_q;

    // Transition detection against the last sampled level.
    always_comb begin
        rise = irq_in & ~last_q;
        fall = ~irq_in & last_q;
    end

    // Per-source next pending state, edge or level variant.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_comb begin
            if (edge_sel[i]) pend_next[i] = (pend_q[i] | rise[i]) & ~clr_bits[i];
            else             pend_next[i] = irq_in[i];
        end
    end

    // Register last level and pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            pend_q <= '0;
        end else begin
            last_q <= irq_in;
            pend_q <= pend_next;
        end
    end

    // R3: a falling edge-mode input never drops its pending bit
    a_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_q & edge_sel & ~clr_bits) & ~pend_q) == '0));
    // R3: a rising edge-mode input sets pending unless cleared in that cycle
    a_r3_edge_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_sel & rise & ~clr_bits) & ~pend_q) == '0));
    // R4: level-mode pending equals the input sampled one edge earlier
    a_r4_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(edge_sel) & (pend_q ^ $past(irq_in))) == '0));
endmodule

// File: rtl/irq_byte_table.sv
// Module: irq_byte_table
// A bank of byte-wide entries written one at a time, with a common reset value.
// Assumes the caller has already range-checked wr_idx.
module irq_byte_table #(
    parameter int         DEPTH   = 64,
    parameter logic [7:0] RST_VAL = 8'h00,
    localparam int        IDXW    = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDXW-1:0]       wr_idx,
    input  logic [7:0]            wr_data,
    output logic [DEPTH-1:0][7:0] entries
);
    // One register per entry, written when selected.
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)                               entries[e] <= RST_VAL;
            else if (wr_en && (wr_idx == IDXW'(e)))   entries[e] <= wr_data;
        end
    end
endmodule

// File: rtl/irq_service.sv
// Module: irq_service
// Runs one assertion and one deassertion evaluation per cycle, each choosing
// the lowest qualifying source, and keeps the in-service register and the
// upstream lines. The deassertion is applied before the assertion.
// Assumes vec_tab low LINEW bits name a valid line (NLINE is a power of two).
module irq_service #(
    parameter int NSRC  = 64,
    parameter int NLINE = 64,
    localparam int IDXW  = $clog2(NSRC),
    localparam int LINEW = $clog2(NLINE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      assert_set,
    input  logic [NSRC-1:0]      deassert_set,
    input  logic [NSRC-1:0]      pend_next,
    input  logic [NSRC-1:0]      mask_next,
    input  logic [NSRC-1:0]      clr_bits,
    input  logic [NSRC-1:0]      isr_wr_mask,
    input  logic [NSRC-1:0]      isr_wr_val,
    input  logic [NSRC-1:0][7:0] vec_tab,
    output logic [NSRC-1:0]      isr_q,
    output logic [NLINE-1:0]     irq_out
);
    logic [NSRC-1:0]  cand_a, cand_d, isr_evt, isr_next;
    logic [IDXW-1:0]  a_idx, d_idx;
    logic             a_valid, d_valid;
    logic [LINEW-1:0] a_line, d_line;
    logic [NLINE-1:0] out_next;

    // Index of the lowest set bit (zero when none).
    function automatic logic [IDXW-1:0] low_idx(input logic [NSRC-1:0] v);
        low_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) if (v[i]) low_idx = IDXW'(i);
    endfunction

    // Candidate sets and lowest-first selection.
    always_comb begin
        cand_a  = assert_set & pend_next & ~mask_next;
        cand_d  = deassert_set & isr_q;
        a_valid = |cand_a;
        d_valid = |cand_d;
        a_idx   = low_idx(cand_a);
        d_idx   = low_idx(cand_d);
        a_line  = vec_tab[a_idx][LINEW-1:0];
        d_line  = vec_tab[d_idx][LINEW-1:0];
    end

    // Next in-service state: deassert, clear, assert, then software overwrite.
    always_comb begin
        isr_evt = isr_q;
        if (d_valid) isr_evt[d_idx] = 1'b0;
        isr_evt = isr_evt & ~clr_bits;
        if (a_valid) isr_evt[a_idx] = 1'b1;
        isr_next = (isr_evt & ~isr_wr_mask) | (isr_wr_val & isr_wr_mask);
    end

    // Next line state: dropped line first, raised line wins on a collision.
    always_comb begin
        out_next = irq_out;
        if (d_valid) out_next[d_line] = 1'b0;
        if (a_valid) out_next[a_line] = 1'b1;
    end

    // Register in-service flags and upstream lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q   <= '0;
            irq_out <= '0;
        end else begin
            isr_q   <= isr_next;
            irq_out <= out_next;
        end
    end

    // R5: never more than one upstream line rises per cycle
    a_r5_one_rise: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(irq_out & ~$past(irq_out)) <= 1));
    // R5: the selected source is in service after the edge
    a_r5_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && !(|isr_wr_mask)) |=> isr_q[$past(a_idx)]);
    // R6: a deasserted line is low after the edge unless reused by an assertion
    a_r6_line_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !a_valid) |=> !irq_out[$past(d_line)]);
    // R9: a software overwrite of in-service leaves the lines alone
    a_r9_isr_wr_lines: assert property (@(posedge clk) disable iff (!rst_n)
        ((|isr_wr_mask) && !a_valid && !d_valid) |=> $stable(irq_out));
endmodule

// File: rtl/irq_agg_ctrl.sv
// Module: irq_agg_ctrl (top)
// Register decode and storage for the interrupt aggregation controller,
// joining capture, the two byte tables and the service logic.
// Assumes one bus access per cycle; reads are combinational on bus_addr.
module irq_agg_ctrl
    import irq_agg_pkg::*;
#(
    parameter int          BUS_W = 32,
    parameter int          NLINE = 64,
    parameter logic [31:0] ID_LO = 32'h0007_0000,
    parameter logic [31:0] ID_HI = 32'h003F_0000,
    localparam int         NSRC  = 2 * BUS_W,
    localparam int         IDXW  = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_in,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [NLINE-1:0]  irq_out
);
    logic [NSRC-1:0] mask_q, edge_q, pol_q, msg_q;
    logic [NSRC-1:0] mask_next, unmasked, newly_masked, clr_raw, clr_bits;
    logic [NSRC-1:0] rise, fall, pend_next, isr_q, isr_wr_mask, isr_wr_val;
    logic [NSRC-1:0] assert_set, deassert_set, status;
    logic [NSRC-1:0][7:0] route_tab, vec_tab;
    logic            idx_ok, route_wr, vec_wr;
    logic [IDXW-1:0] tab_idx;

    // Replace one half of a 64-bit register with the bus word.
    function automatic logic [NSRC-1:0] put_half(input logic [NSRC-1:0] old,
                                                 input logic [BUS_W-1:0] w,
                                                 input logic hi);
        put_half = hi ? {w, old[BUS_W-1:0]} : {old[NSRC-1:BUS_W], w};
    endfunction

    // Decode word writes into mask change sets, clear bits and status overwrite.
    always_comb begin
        mask_next   = mask_q;
        clr_raw     = '0;
        isr_wr_mask = '0;
        isr_wr_val  = '0;
        if (bus_wr) begin
            case (bus_addr)
                A_MASK_LO: mask_next = put_half(mask_q, bus_wdata, 1'b0);
                A_MASK_HI: mask_next = put_half(mask_q, bus_wdata, 1'b1);
                A_CLR_LO:  clr_raw   = {{BUS_W{1'b0}}, bus_wdata};
                A_CLR_HI:  clr_raw   = {bus_wdata, {BUS_W{1'b0}}};
                A_STAT_LO: begin
                    isr_wr_mask = {{BUS_W{1'b0}}, {BUS_W{1'b1}}};
                    isr_wr_val  = {{BUS_W{1'b0}}, bus_wdata};
                end
                A_STAT_HI: begin
                    isr_wr_mask = {{BUS_W{1'b1}}, {BUS_W{1'b0}}};
                    isr_wr_val  = {bus_wdata, {BUS_W{1'b0}}};
                end
                default: ;
            endcase
        end
        unmasked     = mask_q & ~mask_next;
        newly_masked = ~mask_q & mask_next;
        clr_bits     = clr_raw & edge_q;
        assert_set   = rise | unmasked;
        deassert_set = fall | newly_masked | clr_bits;
        status       = isr_q & ~mask_q;
    end

    // Byte-table write decode.
    always_comb begin
        idx_ok   = ({4'h0, bus_addr[7:0]} < 12'(NSRC));
        tab_idx  = bus_addr[IDXW-1:0];
        route_wr = bus_wr && idx_ok && (bus_addr[11:8] == PG_ROUTE);
        vec_wr   = bus_wr && idx_ok && (bus_addr[11:8] == PG_VEC);
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            edge_q <= '0;
            pol_q  <= '0;
            msg_q  <= '0;
        end else begin
            mask_q <= mask_next;
            if (bus_wr) begin
                case (bus_addr)
                    A_EDGE_LO: edge_q <= put_half(edge_q, bus_wdata, 1'b0);
                    A_EDGE_HI: edge_q <= put_half(edge_q, bus_wdata, 1'b1);
                    A_POL_LO:  pol_q  <= put_half(pol_q,  bus_wdata, 1'b0);
                    A_POL_HI:  pol_q  <= put_half(pol_q,  bus_wdata, 1'b1);
                    A_MSG_LO:  msg_q  <= put_half(msg_q,  bus_wdata, 1'b0);
                    A_MSG_HI:  msg_q  <= put_half(msg_q,  bus_wdata, 1'b1);
                    default: ;
                endcase
            end
        end
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr[11:8])
            PG_ROUTE: if (idx_ok) bus_rdata = BUS_W'(route_tab[tab_idx]);
            PG_VEC:   if (idx_ok) bus_rdata = BUS_W'(vec_tab[tab_idx]);
            default: begin
                case (bus_addr)
                    A_ID_LO:   bus_rdata = ID_LO;
                    A_ID_HI:   bus_rdata = ID_HI;
                    A_MASK_LO: bus_rdata = mask_q[BUS_W-1:0];
                    A_MASK_HI: bus_rdata = mask_q[NSRC-1:BUS_W];
                    A_EDGE_LO: bus_rdata = edge_q[BUS_W-1:0];
                    A_EDGE_HI: bus_rdata = edge_q[NSRC-1:BUS_W];
                    A_MSG_LO:  bus_rdata = msg_q[BUS_W-1:0];
                    A_MSG_HI:  bus_rdata = msg_q[NSRC-1:BUS_W];
                    A_STAT_LO: bus_rdata = status[BUS_W-1:0];
                    A_STAT_HI: bus_rdata = status[NSRC-1:BUS_W];
                    A_POL_LO:  bus_rdata = pol_q[BUS_W-1:0];
                    A_POL_HI:  bus_rdata = pol_q[NSRC-1:BUS_W];
                    A_CLR_LO, A_CLR_HI,
                    A_AUTO0, A_AUTO1, A_AUTO2, A_AUTO3: bus_rdata = '0;
                    default:   bus_rdata = '0;
                endcase
            end
        endcase
    end

    irq_capture #(.NSRC(NSRC)) u_capture (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_sel(edge_q),
        .clr_bits(clr_bits), .rise(rise), .fall(fall), .pend_next(pend_next)
    );

    irq_byte_table #(.DEPTH(NSRC), .RST_VAL(8'h01)) u_route (
        .clk(clk), .rst_n(rst_n), .wr_en(route_wr), .wr_idx(tab_idx),
        .wr_data(bus_wdata[7:0]), .entries(route_tab)
    );

    irq_byte_table #(.DEPTH(NSRC), .RST_VAL(8'h00)) u_vec (
        .clk(clk), .rst_n(rst_n), .wr_en(vec_wr), .wr_idx(tab_idx),
        .wr_data(bus_wdata[7:0]), .entries(vec_tab)
    );

    irq_service #(.NSRC(NSRC), .NLINE(NLINE)) u_service (
        .clk(clk), .rst_n(rst_n), .assert_set(assert_set),
        .deassert_set(deassert_set), .pend_next(pend_next),
        .mask_next(mask_next), .clr_bits(clr_bits),
        .isr_wr_mask(isr_wr_mask), .isr_wr_val(isr_wr_val),
        .vec_tab(vec_tab), .isr_q(isr_q), .irq_out(irq_out)
    );

    // R9: status words never show a masked bit
    a_r9_status_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STAT_LO) |-> ((bus_rdata & mask_q[BUS_W-1:0]) == '0));
    // R1: mask is all ones on the first cycle out of reset
    a_r1_mask_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (&mask_q));
    // R11: a mask write is visible at the very next edge
    a_r11_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MASK_LO) |=> (mask_q[BUS_W-1:0] == $past(bus_wdata)));
endmodule

// File: tb/irq_agg_ctrl_test.sv
`timescale 1ns/1ps
module irq_agg_ctrl_test;
    import irq_agg_pkg::*;

    localparam logic [31:0] EXP_ID_LO = 32'h0007_0000;
    localparam int NV = 32;
    // Vector fields: {write(1), addr(12), data/expected(32), requirement(8)}
    localparam logic [52:0] VT [0:NV-1] = '{
        {1'b0, A_MASK_LO, 32'hFFFF_FFFF, 8'd1},   // R1
        {1'b0, A_MASK_HI, 32'hFFFF_FFFF, 8'd1},
        {1'b0, A_EDGE_LO, 32'h0,         8'd1},
        {1'b0, A_STAT_LO, 32'h0,         8'd1},
        {1'b0, 12'h105,   32'h1,         8'd1},
        {1'b0, 12'h205,   32'h0,         8'd1},
        {1'b0, A_ID_LO,   EXP_ID_LO,     8'd2},   // R2
        {1'b1, A_ID_LO,   32'h0,         8'd2},
        {1'b0, A_ID_LO,   EXP_ID_LO,     8'd2},
        {1'b1, A_EDGE_LO, 32'h0000_00F0, 8'd11},  // R11
        {1'b1, A_EDGE_HI, 32'h0000_0003, 8'd2},
        {1'b0, A_EDGE_LO, 32'h0000_00F0, 8'd2},
        {1'b0, A_EDGE_HI, 32'h0000_0003, 8'd2},
        {1'b1, 12'h204,   32'h0000_0045, 8'd10},  // R10
        {1'b0, 12'h204,   32'h0000_0045, 8'd10},
        {1'b1, 12'h150,   32'h0000_0077, 8'd10},
        {1'b0, 12'h150,   32'h0,         8'd10},
        {1'b1, A_AUTO1,   32'h0000_FFFF, 8'd2},
        {1'b0, A_AUTO1,   32'h0,         8'd2},
        {1'b1, A_POL_LO,  32'h0000_1234, 8'd2},
        {1'b0, A_POL_LO,  32'h0000_1234, 8'd2},
        {1'b0, A_POL_HI,  32'h0,         8'd2},
        {1'b1, A_CLR_LO,  32'hFFFF_FFFF, 8'd2},
        {1'b0, A_CLR_LO,  32'h0,         8'd2},
        {1'b1, A_MSG_HI,  32'h0000_0005, 8'd2},
        {1'b0, A_MSG_HI,  32'h0000_0005, 8'd2},
        {1'b1, 12'h202,   32'h0000_0007, 8'd10},
        {1'b1, 12'h208,   32'h0000_000A, 8'd10},
        {1'b1, 12'h209,   32'h0000_000B, 8'd10},
        {1'b1, 12'h228,   32'h0000_003F, 8'd10},
        {1'b0, 12'h13F,   32'h1,         8'd10},
        {1'b0, 12'h240,   32'h0,         8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_out;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_agg_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, {32'h0, bus_rdata}, {32'h0, exp});
    endtask

    task automatic drive(input int bit_i, input logic v);
        @(negedge clk);
        irq_in[bit_i] = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", irq_out, 64'h0);
        // Table walk: register map, halves and byte tables
        for (int k = 0; k < NV; k++) begin
            if (VT[k][52]) wr(VT[k][51:40], VT[k][39:8]);
            else rd_chk($sformatf("R%0d", VT[k][7:0]), VT[k][51:40], VT[k][39:8]);
        end
        // R4 / R7: level source 2 pends while masked, unmask raises line 7
        drive(2, 1'b1);
        check("R4", irq_out, 64'h0);
        wr(A_MASK_LO, 32'hFFFF_FFFB);
        check("R7", irq_out, 64'h1 << 7);
        rd_chk("R9", A_STAT_LO, 32'h4);
        drive(2, 1'b0);
        check("R4", irq_out, 64'h0);
        rd_chk("R6", A_STAT_LO, 32'h0);
        // R3: edge source 4, vector 0x45 -> line 5
        wr(A_MASK_LO, 32'hFFFF_FFEB);
        drive(4, 1'b1);
        check("R3", irq_out, 64'h1 << 5);
        drive(4, 1'b0);
        check("R3", irq_out, 64'h0);
        wr(A_MASK_LO, 32'hFFFF_FFFB);
        check("R7", irq_out, 64'h0);
        wr(A_MASK_LO, 32'hFFFF_FFEB);
        check("R3", irq_out, 64'h1 << 5);   // pending survived the fall
        rd_chk("R9", A_STAT_LO, 32'h10);
        // R8: clear on edge bit retires it
        wr(A_CLR_LO, 32'h10);
        check("R8", irq_out, 64'h0);
        rd_chk("R8", A_STAT_LO, 32'h0);
        wr(A_MASK_LO, 32'hFFFF_FFFB);
        wr(A_MASK_LO, 32'hFFFF_FFEB);
        check("R8", irq_out, 64'h0);
        // R8: clear on level bit 2 is ignored
        drive(2, 1'b1);
        check("R5", irq_out, 64'h1 << 7);
        wr(A_CLR_LO, 32'h4);
        check("R8", irq_out, 64'h1 << 7);
        rd_chk("R8", A_STAT_LO, 32'h4);
        drive(2, 1'b0);
        check("R6", irq_out, 64'h0);
        // R5: lowest-first among sources 8 and 9
        @(negedge clk);
        irq_in[8] = 1'b1; irq_in[9] = 1'b1;
        @(negedge clk);
        check("R5", irq_out, 64'h0);
        wr(A_MASK_LO, 32'hFFFF_FCEB);
        check("R5", irq_out, 64'h1 << 10);
        rd_chk("R5", A_STAT_LO, 32'h100);
        wr(A_MASK_LO, 32'hFFFF_FFEB);
        check("R7", irq_out, 64'h0);
        rd_chk("R7", A_STAT_LO, 32'h0);
        @(negedge clk);
        irq_in[8] = 1'b0; irq_in[9] = 1'b0;
        @(negedge clk);
        // R2: high half, source 40 -> line 63
        wr(A_MASK_HI, 32'hFFFF_FEFF);
        rd_chk("R2", A_MASK_LO, 32'hFFFF_FFEB);
        drive(40, 1'b1);
        check("R5", irq_out, 64'h1 << 63);
        rd_chk("R9", A_STAT_HI, 32'h100);
        drive(40, 1'b0);
        check("R6", irq_out, 64'h0);
        // R9: status overwrite
        wr(A_STAT_LO, 32'h10);
        rd_chk("R9", A_STAT_LO, 32'h10);
        check("R9", irq_out, 64'h0);
        wr(A_STAT_LO, 32'h800);
        rd_chk("R9", A_STAT_LO, 32'h0);
        wr(A_STAT_LO, 32'h0);
        // R1: default vector 0 routes source 3 to line 0
        wr(A_MASK_LO, 32'hFFFF_FFE3);
        check("R7", irq_out, 64'h0);
        drive(3, 1'b1);
        check("R1", irq_out, 64'h1);
        // R1: reset mid-run
        @(negedge clk);
        irq_in = '0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", irq_out, 64'h0);
        rd_chk("R1", A_MASK_LO, 32'hFFFF_FFFF);
        rd_chk("R1", A_EDGE_HI, 32'h0);
        rd_chk("R1", 12'h204, 32'h0);
        rd_chk("R1", A_POL_LO, 32'h0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule